// File: doc/BRIEF.md
# Serial Memory Boot Loader with Address-Width Probing

This block is an SPI master that drives one serial EEPROM or flash through its own chip-select line. It copies the start of that device into a local memory through a plain write port. The block does not need to know in advance how many address bytes the device expects. After `start` it lowers chip select and sends the read command 0x03. It then sends zero bytes one at a time, and after each zero address byte it checks the byte clocked in next. A device that is still collecting address bits leaves the data line pulled high, so it returns 0xFF. The first value other than 0xFF shows that the address phase is over, and the number of zero bytes sent before it is the device's address width.

The byte that revealed the device is the content of device address 0. It is written to local address 0. The block then keeps clocking bytes until it has written `BOOT_BYTES` bytes in total, releases chip select and raises `done`. If the device never answers, the block gives up after three address bytes, raises `err` and releases chip select. The link runs in SPI mode 0, most significant bit first. Each half period of the serial clock lasts `CLK_DIV` system clocks.

Top module: `spi_boot_prober`

## Requirements
- R1: After a synchronous reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done`, `err`, `mem_we` and `addr_width` are all 0.
- R2: The serial clock idles low and `spi_mosi` changes only while `spi_sck` is low. Bits go out most significant first. The first byte of every transaction is the read command 0x03.
- R3: Every byte sent after the command has the value 0x00. This covers the address bytes and all the bytes clocked during data reception.
- R4: The probe byte is the byte clocked in after address byte k, for k = 1, 2 or 3. When the probe byte differs from 0xFF, `addr_width` takes the value k (1, 2 or 3) and holds it until the next start. While no width has been found, `addr_width` reads 0.
- R5: The probe byte that ended detection is written to `mem_addr` 0. The following bytes go to addresses 1, 2 and so on. Exactly `BOOT_BYTES` writes take place, one per `mem_we` pulse, and each has the received byte on `mem_wdata`.
- R6: `spi_cs_n` falls once per transaction and stays low from the command byte through the last data byte. In total 1 + k + `BOOT_BYTES` bytes are clocked. `spi_sck` never pulses while `spi_cs_n` is high.
- R7: `done` rises in the same cycle as the final write. In that cycle `busy` falls and `spi_cs_n` returns high. `done` then stays high until the next start.
- R8: If the probe byte after the third address byte is still 0xFF, `err` rises, `spi_cs_n` returns high, no write takes place, `addr_width` stays 0 and exactly 5 bytes have been clocked. `err` stays high until the next start.
- R9: A `start` pulse while `busy` is high is ignored. It does not restart the transaction or alter the writes.
- R10: Each high phase of `spi_sck` lasts exactly `CLK_DIV` system clock cycles.
- R11: Once a width has been detected, a data byte equal to 0xFF is written like any other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a load; honoured only while idle |
| spi_miso | input | 1 | Serial data from the memory device |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select of the single device, active low |
| spi_mosi | output | 1 | Serial data to the memory device |
| mem_we | output | 1 | Write strobe of the local memory port |
| mem_addr | output | MEM_AW | Write address, counting up from 0 |
| mem_wdata | output | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Load completed; held until the next start |
| err | output | 1 | No device response after three address bytes; held until the next start |
| addr_width | output | 2 | Detected number of address bytes (1 to 3), 0 when none |

## Verification
The bench's device model answers after one, two or three zero address bytes, and in the error run never answers. Each of these runs shows whether the probe stops at the right byte count and whether the detecting byte reaches address 0. The one-byte run places a 0xFF inside the data, which separates a design that keeps probing after detection from one that stops once the width is found. A run repeated after the error shows that `err` is cleared and a fresh probe follows. A `start` pulse sent during the three-byte run must leave the number of chip-select falls at one.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_ADDR, ST_DATA} boot_st_e;
  localparam logic [7:0] BUS_PULLED_UP = 8'hFF;
  localparam int MAX_ADDR_BYTES = 3;
endpackage

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       active,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      active  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        div_cnt <= '0;
        if (go) begin
          active  <= 1'b1;
          tx_sh   <= tx_byte;
          mosi    <= tx_byte[7];
          bit_cnt <= '0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active  <= 1'b0;
            done    <= 1'b1;
            rx_byte <= rx_sh;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
            mosi    <= tx_sh[6];
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  // R2: clock idles low outside a byte
  p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sck);
  // R2: data out only moves while the clock is low
  p_mosi_stable_high_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> !sck);
  // R10: a byte completes on a falling clock edge
  p_done_after_fall_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !sck && !active);
endmodule

// File: rtl/spi_boot_seq.sv
module spi_boot_seq
  import spi_boot_pkg::*;
#(
  parameter int          BOOT_BYTES = 64,
  parameter int          MEM_AW     = 10,
  parameter logic [7:0]  READ_CMD   = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              x_done,
  input  logic [7:0]        rx_byte,
  output logic              go,
  output logic [7:0]        tx_byte,
  output logic              cs_n,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        addr_width
);
  localparam int ZC_W  = $clog2(MAX_ADDR_BYTES + 2);
  localparam int CNT_W = $clog2(BOOT_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(BOOT_BYTES - 1);
  localparam logic [ZC_W-1:0]  ZC_LIMIT  = ZC_W'(MAX_ADDR_BYTES + 1);

  boot_st_e         st;
  logic [ZC_W-1:0]  zcnt;
  logic [CNT_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      zcnt       <= '0;
      wcnt       <= '0;
      go         <= 1'b0;
      tx_byte    <= '0;
      cs_n       <= 1'b1;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      addr_width <= '0;
    end else begin
      go     <= 1'b0;
      mem_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            cs_n       <= 1'b0;
            busy       <= 1'b1;
            done       <= 1'b0;
            err        <= 1'b0;
            addr_width <= '0;
            go         <= 1'b1;
            tx_byte    <= READ_CMD;
            st         <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (x_done) begin
            go      <= 1'b1;
            tx_byte <= 8'h00;
            zcnt    <= ZC_W'(1);
            st      <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (x_done) begin
            if (zcnt >= ZC_W'(2) && rx_byte != BUS_PULLED_UP) begin
              addr_width <= 2'(zcnt - ZC_W'(1));
              mem_we     <= 1'b1;
              mem_addr   <= '0;
              mem_wdata  <= rx_byte;
              wcnt       <= CNT_W'(1);
              if (BOOT_BYTES == 1) begin
                cs_n <= 1'b1;
                busy <= 1'b0;
                done <= 1'b1;
                st   <= ST_IDLE;
              end else begin
                go <= 1'b1;
                st <= ST_DATA;
              end
            end else if (zcnt == ZC_LIMIT) begin
              err  <= 1'b1;
              cs_n <= 1'b1;
              busy <= 1'b0;
              st   <= ST_IDLE;
            end else begin
              zcnt <= zcnt + ZC_W'(1);
              go   <= 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (x_done) begin
            mem_we    <= 1'b1;
            mem_addr  <= MEM_AW'(wcnt);
            mem_wdata <= rx_byte;
            if (wcnt == LAST_IDX) begin
              cs_n <= 1'b1;
              busy <= 1'b0;
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              wcnt <= wcnt + CNT_W'(1);
              go   <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: chip select is released whenever no transaction runs
  p_idle_deselect_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);
  // R5: no write before an address width is known
  p_write_after_detect_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> addr_width != 2'd0);
  // R4: a detected width does not move during the rest of the load
  p_width_hold_r4: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && $past(addr_width) != 2'd0 |-> $stable(addr_width));
  // R8: error leaves the device deselected and no width reported
  p_err_deselect_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> cs_n && addr_width == 2'd0);
  // R7: completion and failure never coexist
  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
endmodule

// File: rtl/spi_boot_prober.sv
module spi_boot_prober #(
  parameter int         CLK_DIV    = 2,
  parameter int         BOOT_BYTES = 64,
  parameter int         MEM_AW     = 10,
  parameter logic [7:0] READ_CMD   = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              spi_miso,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        addr_width
);
  logic       x_go;
  logic [7:0] x_tx;
  logic       x_active;
  logic       x_done;
  logic [7:0] x_rx;

  spi_byte_xfer #(.CLK_DIV(CLK_DIV)) xfer_i (
    .clk     (clk),
    .rst     (rst),
    .go      (x_go),
    .tx_byte (x_tx),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .active  (x_active),
    .done    (x_done),
    .rx_byte (x_rx)
  );

  spi_boot_seq #(
    .BOOT_BYTES (BOOT_BYTES),
    .MEM_AW     (MEM_AW),
    .READ_CMD   (READ_CMD)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .x_done     (x_done),
    .rx_byte    (x_rx),
    .go         (x_go),
    .tx_byte    (x_tx),
    .cs_n       (spi_cs_n),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .addr_width (addr_width)
  );

  // R6: no serial clock activity while deselected
  p_sck_needs_cs_r6: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck && !x_active);
endmodule

// File: tb/spi_boot_prober_tb.sv
module spi_boot_prober_tb_top;
  localparam int CLK_DIV    = 2;
  localparam int BOOT_BYTES = 6;
  localparam int MEM_AW     = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic spi_miso = 1'b1;
  logic spi_sck, spi_cs_n, spi_mosi, mem_we, busy, done, err;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [1:0] addr_width;

  always #4 clk = ~clk;

  spi_boot_prober #(.CLK_DIV(CLK_DIV), .BOOT_BYTES(BOOT_BYTES), .MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .spi_miso(spi_miso),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .err(err), .addr_width(addr_width)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural serial memory: answers after dev_w address bytes (0 = absent)
  int dev_w = 0;
  logic [7:0] dev_mem [16];
  int bitc = 0;
  int bytec = 0;
  logic [7:0] cur = 8'hFF;
  logic [7:0] inb = 8'h00;
  int cs_falls = 0;
  int sck_rises = 0;
  int rxq[$];

  always @(negedge spi_cs_n) begin
    bitc = 0; bytec = 0; cur = 8'hFF; spi_miso = cur[7]; cs_falls++;
  end
  always @(posedge spi_cs_n) spi_miso = 1'b1;
  always @(posedge spi_sck) if (!spi_cs_n) begin
    inb = {inb[6:0], spi_mosi}; bitc++; sck_rises++;
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (bitc == 8) begin
      rxq.push_back(int'(inb));
      bytec++; bitc = 0;
      cur = (dev_w > 0 && bytec >= 1 + dev_w) ? dev_mem[bytec - 1 - dev_w] : 8'hFF;
      spi_miso = cur[7];
    end else begin
      spi_miso = cur[7 - bitc];
    end
  end

  // Reference model: queue of expected writes, compared on every clock
  int exp_addr[$];
  int exp_data[$];
  int hi_len = 0;

  always @(negedge clk) if (!rst) begin
    if (mem_we) begin
      if (exp_addr.size() == 0) chk(1'b0, "R5", "unexpected write addr", int'(mem_addr), -1);
      else begin
        int ea, ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        chk(int'(mem_addr) == ea, "R5", "write address", int'(mem_addr), ea);
        chk(int'(mem_wdata) == ed, (ed == 255) ? "R11" : "R5", "write data", int'(mem_wdata), ed);
      end
    end
    if (spi_cs_n && spi_sck) chk(1'b0, "R6", "sck while deselected", 1, 0);
    if (spi_sck) hi_len++;
    else if (hi_len != 0) begin
      chk(hi_len == CLK_DIV, "R10", "sck high length", hi_len, CLK_DIV);
      hi_len = 0;
    end
  end

  task automatic run(input int w, input bit mid_start);
    int n;
    dev_w = w;
    for (int i = 0; i < 16; i++) dev_mem[i] = 8'(i * 37 + w * 11 + 5);
    if (w == 1) dev_mem[3] = 8'hFF;
    rxq.delete(); exp_addr.delete(); exp_data.delete();
    cs_falls = 0; sck_rises = 0;
    if (w > 0) for (int i = 0; i < BOOT_BYTES; i++) begin
      exp_addr.push_back(i); exp_data.push_back(int'(dev_mem[i]));
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!(done || err) && n < 20000) begin
      @(negedge clk); n++;
      if (mid_start && n == 40) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (w > 0) begin
      chk(done == 1'b1, "R7", "done raised", int'(done), 1);
      chk(err == 1'b0, "R7", "err low on success", int'(err), 0);
      chk(int'(addr_width) == w, "R4", "detected width", int'(addr_width), w);
      chk(sck_rises == 8 * (1 + w + BOOT_BYTES), "R6", "sck rises", sck_rises, 8 * (1 + w + BOOT_BYTES));
    end else begin
      chk(err == 1'b1, "R8", "err raised", int'(err), 1);
      chk(done == 1'b0, "R8", "done low on error", int'(done), 0);
      chk(int'(addr_width) == 0, "R8", "width on error", int'(addr_width), 0);
      chk(sck_rises == 40, "R8", "sck rises", sck_rises, 40);
    end
    chk(busy == 1'b0 && spi_cs_n == 1'b1, "R7", "idle and deselected", int'({busy, spi_cs_n}), 1);
    chk(cs_falls == 1, mid_start ? "R9" : "R6", "chip select falls", cs_falls, 1);
    repeat (6) @(negedge clk);
    chk(exp_addr.size() == 0, "R5", "writes left", exp_addr.size(), 0);
    chk(rxq.size() > 0 && rxq[0] == 3, "R2", "command byte", rxq.size() > 0 ? rxq[0] : -1, 3);
    for (int i = 1; i < rxq.size(); i++)
      if (rxq[i] != 0) chk(1'b0, "R3", "zero byte sent", rxq[i], 0);
    chk(1'b1, "R3", "zero bytes scanned", 0, 0);
    chk((w > 0 ? done : err) == 1'b1, w > 0 ? "R7" : "R8", "flag held", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "reset pins", int'({spi_cs_n, spi_sck}), 2);
    chk({busy, done, err, mem_we} == 4'b0, "R1", "reset flags", int'({busy, done, err, mem_we}), 0);
    chk(addr_width == 2'd0, "R1", "reset width", int'(addr_width), 0);
    run(1, 1'b0);
    run(2, 1'b0);
    run(3, 1'b1);
    run(0, 1'b0);
    run(2, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule